// File: doc/BRIEF.md
# Two-Master Parking Bus Arbiter

This block decides which of two masters owns an internal bus: a processor core or a DMA engine. Each master raises a request line. The owner signals the end of its transfer with a one-cycle done strobe. A two-bit policy field, held in a small register, selects one of four policies:

- alternate ownership between the two masters;
- always favour the core;
- always favour the DMA;
- let the current owner keep the bus.

In the alternating policy, a DMA bandwidth code of zero means the DMA runs at maximum bandwidth, and the DMA is then favoured over the core.

Grants are registered and one-hot. A grant lasts from the edge after an arbitration point until the edge after the owner's done strobe. An arbitration point is any cycle in which the bus has no owner, or in which the owner pulses done. A priority flag shows which master would be favoured at the next arbitration point. The policy register can be written at any time, but it is consulted only at arbitration points.

Top module: `park_arbiter`

## Requirements
- R1: After reset no grant is asserted, the priority flag points to the core (dma_pri = 0) and the policy reads 00.
- R2: core_gnt and dma_gnt are never both high.
- R3: While a master is granted and xfer_done is low, both grants hold their values, whatever happens on the requests, the bandwidth code or the policy writes.
- R4: Policy 00 with a bandwidth code other than 000: at an arbitration point the master named by dma_pri wins if it requests, otherwise the other master wins if it requests. After a grant, dma_pri names the master that did not win.
- R5: Policy 00 with bandwidth code 000: the DMA wins any arbitration point at which it requests.
- R6: Policy 01: the core wins whenever it requests at an arbitration point, the DMA wins only when the core does not request, and dma_pri becomes 0 at every arbitration point.
- R7: Policy 10: the DMA wins whenever it requests at an arbitration point, the core wins only when the DMA does not request, and dma_pri becomes 1 at every arbitration point.
- R8: Policy 11: the master named by dma_pri keeps winning while it requests. The other master wins only at an arbitration point where the favoured master does not request, and dma_pri then names the new owner.
- R9: With no request at an arbitration point, both grants go low on the next edge and dma_pri keeps its value, except under policies 01 and 10. A request raised while the bus is idle is granted on the next edge, with no extra cycle.
- R10: mode_we loads mode_wdata into the policy register, which appears on mode on the next edge. A write during a transfer does not change the current grant and first affects the next arbitration point.
- R11: A grant rises only for a master whose request was high at the edge where it rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core bus request |
| dma_req | input | 1 | DMA bus request |
| xfer_done | input | 1 | Current owner finishes its transfer this cycle |
| dma_bw | input | BW_W | DMA bandwidth code (000 = maximum bandwidth) |
| mode_we | input | 1 | Policy register write enable |
| mode_wdata | input | 2 | Policy value to write |
| core_gnt | output | 1 | Bus granted to the core |
| dma_gnt | output | 1 | Bus granted to the DMA |
| dma_pri | output | 1 | 1 when the DMA is favoured at the next arbitration point |
| mode | output | 2 | Policy register contents |

## Verification
The bench holds both requests high and strobes done at a fixed interval under each policy. This separates alternation, the bandwidth override and the three parking rules, because only the order of winners differs between them. Random request and done patterns then exercise the fall-back cases, where the favoured master is silent at an arbitration point. Spells with no requests show that the bus goes idle and that a request raised while idle is granted on the next edge. Policy writes landing in the middle of transfers show that a write changes no grant until the owner finishes.

// File: rtl/park_arbiter.sv
module park_arbiter #(
  parameter int BW_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_req,
  input  logic            dma_req,
  input  logic            xfer_done,
  input  logic [BW_W-1:0] dma_bw,
  input  logic            mode_we,
  input  logic [1:0]      mode_wdata,
  output logic            core_gnt,
  output logic            dma_gnt,
  output logic            dma_pri,
  output logic [1:0]      mode
);
  localparam logic [1:0] M_RR = 2'b00, M_CORE = 2'b01, M_DMA = 2'b10;

  logic [1:0] gnt_q, mode_q, win;
  logic       pri_q, pref, pri_nxt;

  wire [1:0] req = {dma_req, core_req};
  wire       arb = (gnt_q == 2'b00) || xfer_done;

  always_comb begin
    case (mode_q)
      M_RR:    pref = (dma_bw == '0) ? 1'b1 : pri_q;
      M_CORE:  pref = 1'b0;
      M_DMA:   pref = 1'b1;
      default: pref = pri_q;
    endcase
  end

  always_comb begin
    if (req[pref])       win = pref ? 2'b10 : 2'b01;
    else if (req[!pref]) win = pref ? 2'b01 : 2'b10;
    else                 win = 2'b00;
  end

  always_comb begin
    case (mode_q)
      M_RR:    pri_nxt = (win != 2'b00) ? win[0] : pri_q;
      M_CORE:  pri_nxt = 1'b0;
      M_DMA:   pri_nxt = 1'b1;
      default: pri_nxt = (win != 2'b00) ? win[1] : pri_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= 2'b00;
      pri_q  <= 1'b0;
      mode_q <= M_RR;
    end else begin
      if (arb) begin
        gnt_q <= win;
        pri_q <= pri_nxt;
      end
      if (mode_we) mode_q <= mode_wdata;
    end
  end

  assign core_gnt = gnt_q[0];
  assign dma_gnt  = gnt_q[1];
  assign dma_pri  = pri_q;
  assign mode     = mode_q;

  // R2
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_gnt && dma_gnt));

  // R3
  hold_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_gnt || dma_gnt) && !xfer_done) |=> ($stable(core_gnt) && $stable(dma_gnt)));

  // R6
  park_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb && mode == M_CORE && core_req) |=> (core_gnt && !dma_pri));

  // R7
  park_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb && mode == M_DMA && dma_req) |=> (dma_gnt && dma_pri));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb && !core_req && !dma_req) |=> (!core_gnt && !dma_gnt));

  // R11
  core_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_gnt) |-> $past(core_req));

  // R11
  dma_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_gnt) |-> $past(dma_req));
endmodule

// File: tb/park_arbiter_test.sv
`timescale 1ns/1ps
module park_arbiter_test;
  logic clk = 0, rst_n = 0;
  logic core_req = 0, dma_req = 0, xfer_done = 0, mode_we = 0;
  logic [2:0] dma_bw = 3'd3;
  logic [1:0] mode_wdata = 0;
  logic core_gnt, dma_gnt, dma_pri;
  logic [1:0] mode;

  int vectors = 0, fails = 0;
  bit checking = 0;
  string tag = "R1";

  // reference model: owner 0 none, 1 core, 2 dma; pri 0 core, 1 dma
  int m_own = 0, m_pri = 0, m_mode = 0;
  bit e_creq, e_dreq;

  park_arbiter uut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    e_creq = core_req;
    e_dreq = dma_req;
    if (!rst_n) begin
      m_own = 0; m_pri = 0; m_mode = 0;
    end else begin
      if (m_own == 0 || xfer_done) begin
        int fav, w;
        bit r [2];
        r[0] = core_req; r[1] = dma_req;
        if (m_mode == 1) fav = 0;
        else if (m_mode == 2) fav = 1;
        else if (m_mode == 0 && dma_bw == 0) fav = 1;
        else fav = m_pri;
        w = -1;
        if (r[fav]) w = fav;
        else if (r[1-fav]) w = 1 - fav;
        m_own = w + 1;
        if (m_mode == 1) m_pri = 0;
        else if (m_mode == 2) m_pri = 1;
        else if (w >= 0) m_pri = (m_mode == 0) ? 1 - w : w;
      end
      if (mode_we) m_mode = mode_wdata;
    end
  end

  task automatic chk(string t, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  bit pc = 0, pd = 0;
  always @(negedge clk) if (checking) begin
    chk(tag, "grant owner", dma_gnt ? 2 : (core_gnt ? 1 : 0), m_own);
    chk(tag, "dma_pri", dma_pri, m_pri);
    chk("R10", "mode", mode, m_mode);
    chk("R2", "grant pair", core_gnt & dma_gnt, 0);
    if (core_gnt && !pc) chk("R11", "core req at rise", e_creq, 1);
    if (dma_gnt && !pd) chk("R11", "dma req at rise", e_dreq, 1);
    pc = core_gnt; pd = dma_gnt;
  end

  task automatic drive(bit c, bit d, bit dn, bit [2:0] bw, bit we, bit [1:0] wd);
    @(posedge clk); #1;
    core_req = c; dma_req = d; xfer_done = dn; dma_bw = bw;
    mode_we = we; mode_wdata = wd;
  endtask

  task automatic setmode(bit [1:0] m);
    drive(0, 0, 1, 3'd3, 1, m);
    drive(0, 0, 1, 3'd3, 0, 0);
  endtask

  task automatic saturate(int n, bit [2:0] bw);
    for (int i = 0; i < n; i++) drive(1, 1, (i % 3) == 2, bw, 0, 0);
  endtask

  task automatic rnd(int n, bit [2:0] bw, bit writes);
    for (int i = 0; i < n; i++)
      drive($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 3) == 0),
            bw, writes && ($urandom_range(0, 7) == 0), 2'($urandom_range(0, 3)));
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    tag = "R1";
    chk("R1", "core_gnt", core_gnt, 0);
    chk("R1", "dma_gnt", dma_gnt, 0);
    chk("R1", "dma_pri", dma_pri, 0);
    chk("R1", "mode", mode, 0);
    checking = 1;
    tag = "R4"; saturate(18, 3'd5); rnd(60, 3'd2, 0);
    tag = "R5"; saturate(15, 3'd0); rnd(60, 3'd0, 0);
    tag = "R6"; setmode(2'b01); saturate(12, 3'd0); rnd(60, 3'd4, 0);
    tag = "R7"; setmode(2'b10); saturate(12, 3'd4); rnd(60, 3'd1, 0);
    tag = "R8"; setmode(2'b11); saturate(12, 3'd1);
    drive(0, 1, 1, 3'd1, 0, 0); drive(1, 1, 0, 3'd1, 0, 0); drive(1, 1, 1, 3'd1, 0, 0);
    rnd(60, 3'd7, 0);
    tag = "R9"; setmode(2'b00);
    repeat (4) drive(0, 0, 0, 3'd3, 0, 0);
    drive(0, 1, 0, 3'd3, 0, 0); drive(0, 0, 0, 3'd3, 0, 0);
    repeat (3) drive(0, 0, 1, 3'd3, 0, 0);
    drive(1, 0, 0, 3'd3, 0, 0); drive(0, 0, 1, 3'd3, 0, 0); drive(0, 0, 0, 3'd3, 0, 0);
    tag = "R10";
    drive(1, 1, 0, 3'd3, 0, 0);
    drive(1, 1, 0, 3'd3, 1, 2'b10); drive(0, 1, 0, 3'd3, 0, 0);
    drive(1, 1, 1, 3'd3, 0, 0); drive(1, 1, 0, 3'd3, 0, 0);
    rnd(300, 3'd3, 1);
    tag = "R3"; rnd(400, 3'd0, 1); rnd(400, 3'd6, 1);
    checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule